// File: doc/BRIEF.md
# Multilevel Carry-Select Wide Adder

This block adds two 256-bit unsigned operands and a carry-in and returns a 256-bit sum with a carry-out. It has no clock and no storage: every output is a pure function of the present inputs. Its port list is the same as that of any other adder variant of the same width, so it can replace a plain `+` expression or another adder structure without touching the surrounding logic.

Internally the operand is cut into eight 32-bit ripple-carry segments. The lowest segment takes the real carry-in. Every other segment is built twice, one copy assuming an incoming carry of 0 and one assuming 1. At the first selection level, two neighbouring segments form a 64-bit group: inside the group the upper segment's result is picked by the lower segment's carry, separately for each assumed group carry, so each group yields two complete 64-bit results and two group carries. At the second level the true carry moves from group to group through one multiplexer per group and picks each group's result. The longest path is one 32-bit ripple, one in-group select and three group selects, instead of eight ripples in series.

Top module: `csel_add256`

## Requirements
- R1: For every input, the 257-bit value {carry_out, sum} equals op_a + op_b + carry_in taken as unsigned numbers.
- R2: The lowest 32 bits of sum (bits 31..0) equal op_a[31:0] + op_b[31:0] + carry_in modulo 2^32, so carry_in reaches bit 0 directly.
- R3: Each of the eight 32-bit slices k of sum (bits 32k+31..32k) equals the slice of op_a plus the slice of op_b plus the true carry arriving at bit 32k, modulo 2^32.
- R4: When every bit below a 64-bit group boundary propagates (op_a XOR op_b is all ones there), the group above it receives carry_in unchanged as its incoming carry.
- R5: When op_a XOR op_b is all ones over all 256 bits, sum is all ones when carry_in is 0 and all zeros with carry_out 1 when carry_in is 1.
- R6: When op_b is zero and carry_in is 0, sum equals op_a and carry_out is 0.
- R7: carry_out is 1 exactly when op_a + op_b + carry_in is 2^256 or larger.
- R8: The outputs follow a change of the inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 256 | First unsigned operand |
| op_b | input | 256 | Second unsigned operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 256 | Low 256 bits of the result |
| carry_out | output | 1 | Carry out of bit 255 |

## Verification
The bench aims at the carry paths that cross segment and group boundaries: an all-ones operand plus one, a propagate chain over all 256 bits driven only by carry_in, and operands that ripple exactly to bit 32 or bit 64. A design that swapped the two segment copies, or fed a select with the carry of the wrong segment or group, would return a sum off by 2^32 or 2^64 in one slice, or lose the carry-out when the whole word propagates. The maximum case (both operands all ones, carry_in set) and random vectors catch a wrong generate term, and an input change with no clock edge in between shows that nothing is stored.

// File: rtl/csa_pkg.sv
package csa_pkg;

    // Index of the copy built for each assumed incoming carry.
    localparam int ASSUME_ZERO = 0;
    localparam int ASSUME_ONE  = 1;
    localparam int N_ASSUME    = 2;

    function automatic int piece_count(input int total, input int piece);
        return total / piece;
    endfunction

endpackage

// File: rtl/csa_rca_seg.sv
module csa_rca_seg #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic         cout
);

    logic [W:0] rip;

    assign rip[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic half;
        assign half     = a[i] ^ b[i];
        assign s[i]     = half ^ rip[i];
        assign rip[i+1] = (a[i] & b[i]) | (half & rip[i]);
    end

    assign cout = rip[W];

endmodule

// File: rtl/csa_dual_seg.sv
module csa_dual_seg
    import csa_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]                  a,
    input  logic [W-1:0]                  b,
    output logic [N_ASSUME-1:0][W-1:0]    s,
    output logic [N_ASSUME-1:0]           cout
);

    for (genvar k = 0; k < N_ASSUME; k++) begin : g_copy
        csa_rca_seg #(.W(W)) u_rca (
            .a    (a),
            .b    (b),
            .cin  (k == ASSUME_ONE),
            .s    (s[k]),
            .cout (cout[k])
        );
    end

endmodule

// File: rtl/csa_group_sel.sv
module csa_group_sel
    import csa_pkg::*;
#(
    parameter int SEG_W    = 32,
    parameter int GRP_SEGS = 2,
    localparam int GRP_W   = SEG_W * GRP_SEGS
) (
    input  logic [GRP_W-1:0]                 a,
    input  logic [GRP_W-1:0]                 b,
    output logic [N_ASSUME-1:0][GRP_W-1:0]   s,
    output logic [N_ASSUME-1:0]              cout
);

    for (genvar j = 0; j < GRP_SEGS; j++) begin : g_seg
        logic [N_ASSUME-1:0][SEG_W-1:0] ps;
        logic [N_ASSUME-1:0]            pc;

        csa_dual_seg #(.W(SEG_W)) u_dual (
            .a    (a[j*SEG_W +: SEG_W]),
            .b    (b[j*SEG_W +: SEG_W]),
            .s    (ps),
            .cout (pc)
        );
    end

    // One carry chain per assumed group carry (level-1 selection).
    for (genvar k = 0; k < N_ASSUME; k++) begin : g_assume
        logic [GRP_SEGS:0] chain;
        assign chain[0] = (k == ASSUME_ONE);

        for (genvar j = 0; j < GRP_SEGS; j++) begin : g_pick
            assign s[k][j*SEG_W +: SEG_W] = chain[j] ? g_seg[j].ps[ASSUME_ONE]
                                                     : g_seg[j].ps[ASSUME_ZERO];
            assign chain[j+1] = chain[j] ? g_seg[j].pc[ASSUME_ONE]
                                         : g_seg[j].pc[ASSUME_ZERO];
        end

        assign cout[k] = chain[GRP_SEGS];
    end

endmodule

// File: rtl/csel_add256.sv
module csel_add256
    import csa_pkg::*;
#(
    parameter int WIDTH    = 256,
    parameter int SEG_W    = 32,
    parameter int GRP_SEGS = 2
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);

    localparam int GRP_W = SEG_W * GRP_SEGS;
    localparam int N_GRP = piece_count(WIDTH, GRP_W);

    // True carry entering each group (level-2 selection chain).
    logic [N_GRP:0] grp_c;

    assign grp_c[0] = carry_in;

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        if (g == 0) begin : g_base
            // Lowest group: bottom segment sees the real carry directly.
            logic [GRP_SEGS:0] lc;
            assign lc[0] = grp_c[0];

            csa_rca_seg #(.W(SEG_W)) u_low (
                .a    (op_a[SEG_W-1:0]),
                .b    (op_b[SEG_W-1:0]),
                .cin  (lc[0]),
                .s    (sum[SEG_W-1:0]),
                .cout (lc[1])
            );

            for (genvar j = 1; j < GRP_SEGS; j++) begin : g_up
                logic [N_ASSUME-1:0][SEG_W-1:0] ps;
                logic [N_ASSUME-1:0]            pc;

                csa_dual_seg #(.W(SEG_W)) u_dual (
                    .a    (op_a[j*SEG_W +: SEG_W]),
                    .b    (op_b[j*SEG_W +: SEG_W]),
                    .s    (ps),
                    .cout (pc)
                );

                assign sum[j*SEG_W +: SEG_W] = lc[j] ? ps[ASSUME_ONE] : ps[ASSUME_ZERO];
                assign lc[j+1]               = lc[j] ? pc[ASSUME_ONE] : pc[ASSUME_ZERO];
            end

            assign grp_c[1] = lc[GRP_SEGS];
        end else begin : g_sel
            logic [N_ASSUME-1:0][GRP_W-1:0] gs;
            logic [N_ASSUME-1:0]            gc;

            csa_group_sel #(.SEG_W(SEG_W), .GRP_SEGS(GRP_SEGS)) u_grp (
                .a    (op_a[g*GRP_W +: GRP_W]),
                .b    (op_b[g*GRP_W +: GRP_W]),
                .s    (gs),
                .cout (gc)
            );

            assign sum[g*GRP_W +: GRP_W] = grp_c[g] ? gs[ASSUME_ONE] : gs[ASSUME_ZERO];
            assign grp_c[g+1]            = grp_c[g] ? gc[ASSUME_ONE] : gc[ASSUME_ZERO];
        end
    end

    assign carry_out = grp_c[N_GRP];

endmodule

// File: rtl/csel_add256_chk.sv
module csel_add256_chk #(
    parameter int WIDTH    = 256,
    parameter int SEG_W    = 32,
    parameter int GRP_SEGS = 2
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             carry_in,
    input logic [WIDTH-1:0] sum,
    input logic             carry_out
);

    localparam int GRP_W = SEG_W * GRP_SEGS;
    localparam int N_SEG = WIDTH / SEG_W;
    localparam int N_GRP = WIDTH / GRP_W;

    logic [WIDTH:0]   ref_sum;
    logic [WIDTH-1:0] carry_at;
    logic [WIDTH-1:0] prop;

    assign ref_sum  = {1'b0, op_a} + {1'b0, op_b} + (WIDTH+1)'(carry_in);
    assign carry_at = ref_sum[WIDTH-1:0] ^ op_a ^ op_b;
    assign prop     = op_a ^ op_b;

    always_comb begin
        // R1: complete 257-bit result
        a_r1_full_result: assert ({carry_out, sum} == ref_sum)
            else $error("R1 result mismatch");
        // R2: bottom segment driven by carry_in
        a_r2_low_segment: assert (sum[SEG_W-1:0] ==
                                  SEG_W'(op_a[SEG_W-1:0] + op_b[SEG_W-1:0] + SEG_W'(carry_in)))
            else $error("R2 low segment mismatch");
        // R5: full propagate
        if (&prop) begin
            a_r5_full_propagate: assert (sum == {WIDTH{~carry_in}} && carry_out == carry_in)
                else $error("R5 propagate mismatch");
        end
        // R6: zero addend
        if (op_b == '0 && !carry_in) begin
            a_r6_zero_addend: assert (sum == op_a && !carry_out)
                else $error("R6 identity mismatch");
        end
        // R7: carry out only on overflow of 256 bits
        a_r7_carry_out: assert (carry_out == ref_sum[WIDTH])
            else $error("R7 carry-out mismatch");
    end

    for (genvar k = 0; k < N_SEG; k++) begin : g_seg_chk
        always_comb begin
            // R3: each slice uses the true incoming carry
            a_r3_segment_slice: assert (sum[k*SEG_W +: SEG_W] ==
                SEG_W'(op_a[k*SEG_W +: SEG_W] + op_b[k*SEG_W +: SEG_W] + SEG_W'(carry_at[k*SEG_W])))
                else $error("R3 segment %0d mismatch", k);
        end
    end

    for (genvar g = 1; g < N_GRP; g++) begin : g_grp_chk
        always_comb begin
            // R4: carry_in passes unchanged through a propagating lower part
            if (&prop[g*GRP_W-1:0]) begin
                a_r4_group_pass: assert (sum[g*GRP_W +: GRP_W] ==
                    GRP_W'(op_a[g*GRP_W +: GRP_W] + op_b[g*GRP_W +: GRP_W] + GRP_W'(carry_in)))
                    else $error("R4 group %0d mismatch", g);
            end
        end
    end

endmodule

bind csel_add256 csel_add256_chk #(
    .WIDTH    (WIDTH),
    .SEG_W    (SEG_W),
    .GRP_SEGS (GRP_SEGS)
) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum       (sum),
    .carry_out (carry_out)
);

// File: tb/sim_csel_add256.sv
module sim_csel_add256;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 256;
    localparam int SW         = 32;
    localparam int N_VEC      = 8;
    localparam int N_RAND     = 60;
    localparam int WATCHDOG   = 100000;

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         ci;
        logic [7:0]   req;
    } vec_t;

    localparam logic [W-1:0] ONES = {W{1'b1}};
    localparam logic [W-1:0] ONE  = W'(1);

    localparam vec_t VEC [N_VEC] = '{
        '{a: ONES,                  b: '0,                 ci: 1'b1, req: 8'd5}, // R5 chain fed by carry_in
        '{a: ONES,                  b: ONE,                ci: 1'b0, req: 8'd7}, // R7 all ones plus one
        '{a: {8{32'hDEADBEEF}},     b: '0,                 ci: 1'b0, req: 8'd6}, // R6 zero addend
        '{a: W'(32'hFFFFFFFF),      b: ONE,                ci: 1'b0, req: 8'd2}, // R2 ripple to bit 32
        '{a: W'(64'hFFFFFFFFFFFFFFFF), b: ONE,             ci: 1'b0, req: 8'd4}, // R4 ripple to bit 64
        '{a: ONES,                  b: ONES,               ci: 1'b1, req: 8'd7}, // R7 maximum
        '{a: '0,                    b: '0,                 ci: 1'b1, req: 8'd2}, // R2 carry_in alone
        '{a: {64{4'h5}},            b: {64{4'hA}},         ci: 1'b1, req: 8'd5}  // R5 mixed propagate
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         carry_in = 1'b0;
    logic [W-1:0] sum;
    logic         carry_out;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csel_add256 u0 (
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .sum       (sum),
        .carry_out (carry_out)
    );

    function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y,
                                            input logic c);
        return {1'b0, x} + {1'b0, y} + (W+1)'(c);
    endfunction

    task automatic check(input int req, input logic [W:0] got, input logic [W:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL R%0d got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
        @(posedge clk);
        op_a     = x;
        op_b     = y;
        carry_in = c;
        @(negedge clk);
    endtask

    // R3: every 32-bit slice against its own slice addition with the true carry
    task automatic check_slices();
        logic [W:0]   r;
        logic [W-1:0] cat;
        logic         ok;
        r   = ref_add(op_a, op_b, carry_in);
        cat = r[W-1:0] ^ op_a ^ op_b;
        ok  = 1'b1;
        for (int k = 0; k < W/SW; k++) begin
            logic [SW-1:0] e;
            e = op_a[k*SW +: SW] + op_b[k*SW +: SW] + SW'(cat[k*SW]);
            if (sum[k*SW +: SW] !== e) ok = 1'b0;
        end
        check(3, {W'(0), ok}, {W'(0), 1'b1});
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                total++;
                bad++;
                $display("FAIL watchdog expired got=%0d exp<=%0d", cycles, WATCHDOG);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state: zero inputs give zero outputs (R1)
        check(1, {carry_out, sum}, '0);

        // Table of directed vectors
        for (int i = 0; i < N_VEC; i++) begin
            apply(VEC[i].a, VEC[i].b, VEC[i].ci);
            check(int'(VEC[i].req), {carry_out, sum}, ref_add(VEC[i].a, VEC[i].b, VEC[i].ci));
            check_slices();
        end

        // R5: propagate-all with carry_in 0 gives all ones, no carry out
        apply(ONES, '0, 1'b0);
        check(5, {carry_out, sum}, {1'b0, ONES});

        // R4: ripple through two groups into the third
        apply({128'h0, {128{1'b1}}}, ONE, 1'b0);
        check(4, {carry_out, sum}, (W+1)'({129'h1, 128'h0}));

        // R2: low segment with carry_in only
        apply(W'(32'h7FFFFFFF), '0, 1'b1);
        check(2, {W'(0), sum[SW-1:0]}, {W'(0), 32'h80000000});

        // R8: change inputs between edges, no clock edge before sampling
        @(negedge clk);
        op_a     = ONES;
        op_b     = '0;
        carry_in = 1'b1;
        #1;
        check(8, {carry_out, sum}, {1'b1, W'(0)});

        // R1/R7: random vectors
        for (int n = 0; n < N_RAND; n++) begin
            logic [W-1:0] x, y;
            logic         c;
            for (int w = 0; w < W/32; w++) begin
                x[w*32 +: 32] = $urandom;
                y[w*32 +: 32] = $urandom;
            end
            c = 1'($urandom);
            apply(x, y, c);
            check(1, {carry_out, sum}, ref_add(x, y, c));
            check_slices();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule